// File: doc/BRIEF.md
# Message Interrupt Pending Bank

This block terminates posted message-signalled interrupt writes. Each incoming write carries an address that names one of 128 pending registers (16 groups of 8) and a data value that names one of 16 bits inside that register. The block sets that bit and holds it until software reads the register. The read returns the contents and empties the register in the same operation.

For every group the block forms an 8-bit summary. Bit x of the summary is set when pending register x of that group holds any set bit. Each group drives one interrupt line, which stays high while its summary is nonzero. A handler reads the summary to find which pending registers to drain. It then reads those registers, which clears them, and the line drops once the group is empty. A write and a clearing read that reach the same register in one cycle are merged, so the written bit is not lost.

Top module: `msi_term_bank`

## Requirements
- R1: A write with `wr_en` high to address `(g << 19) + (x << 16)` (g from 0 to 15, x from 0 to 7) and data d from 0 to 15 sets bit d of pending register (g, x).
- R2: A write whose data value is 16 or greater sets no bit anywhere.
- R3: A write whose address is not exactly a pending register address sets no bit and leaves every register unchanged. This covers nonzero bits 15:0, summary addresses and addresses at or above 0x800000.
- R4: `rd_data` is registered. It shows the result of a read on the cycle after the clock edge that sampled `rd_en`, and it shows zero after an edge where `rd_en` was low.
- R5: Reading a pending register returns its whole contents zero-extended to 32 bits, and leaves the register empty.
- R6: If a write and a read reach the same pending register in one cycle, the read returns the old contents and the written bit is set afterwards, so the next read returns it.
- R7: The summary for group g is read at `0x800000 + (g << 16)`. Its bit x is 1 exactly when pending register (g, x) is nonzero, and reading it changes nothing.
- R8: `irq_out[g]` is high exactly while some pending register of group g is nonzero. It falls once every nonempty register of the group has been read with no new writes.
- R9: A read of an address that matches neither a pending register nor a summary register returns zero and changes nothing.
- R10: Reset (`rst_n` low, asynchronous) empties every pending register, drives all of `irq_out` low and zeroes `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Message write strobe |
| wr_addr | input | 24 | Message write byte offset |
| wr_data | input | 32 | Message write data (vector bit number) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 24 | Register read byte offset |
| rd_data | output | 32 | Read result, one cycle after the strobe |
| irq_out | output | 16 | One interrupt line per group |

## Verification
A write takes effect at the clock edge that samples it. The affected `irq_out` line and any later read reflect it from that edge onward. Read data appears after the edge that sampled `rd_en` and holds for one cycle. The bench therefore drives every operation just after a falling edge and waits for the next rising edge. It samples `rd_data` and `irq_out` at the following falling edge. The expected read value is taken from the bench model before that model applies the same cycle's clear and set, in that order, which is the merge that R6 requires.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;

  // Kind of register an address selects
  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_PENDING = 2'd1,
    SEL_SUMMARY = 2'd2
  } sel_kind_e;

  // Flat position of pending register (grp, idx)
  function automatic int unsigned flat_slot(input int unsigned grp,
                                            input int unsigned idx,
                                            input int unsigned per_grp);
    return grp * per_grp + idx;
  endfunction

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned GROUPS    = 16,
  parameter int unsigned INDEXES   = 8,
  parameter int unsigned REG_SHIFT = 16,
  localparam int unsigned GRP_W    = $clog2(GROUPS),
  localparam int unsigned IDX_W    = $clog2(INDEXES)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_kind_e         kind,
  output logic [GRP_W-1:0]  grp,
  output logic [IDX_W-1:0]  idx
);
  // Pending registers sit below 1 << TOP_SH; summaries start there
  localparam int unsigned TOP_SH = REG_SHIFT + IDX_W + GRP_W;
  localparam int unsigned SUM_SH = REG_SHIFT + GRP_W;

  logic               low_zero;
  logic [ADDR_W-1:0]  above_top;
  logic [TOP_SH-1:0]  below_top;
  logic [GRP_W-1:0]   p_grp;
  logic [IDX_W-1:0]   p_idx;
  logic [GRP_W-1:0]   s_grp;
  logic               p_hit;
  logic               s_hit;

  assign low_zero  = (addr[REG_SHIFT-1:0] == '0);
  assign above_top = addr >> TOP_SH;
  assign below_top = addr[TOP_SH-1:0];
  assign p_idx     = addr[REG_SHIFT +: IDX_W];
  assign p_grp     = addr[REG_SHIFT+IDX_W +: GRP_W];
  assign s_grp     = addr[REG_SHIFT +: GRP_W];

  assign p_hit = low_zero && (above_top == '0) &&
                 (32'(p_grp) < GROUPS) && (32'(p_idx) < INDEXES);
  assign s_hit = low_zero && (above_top == ADDR_W'(1)) &&
                 ((below_top >> SUM_SH) == '0) && (32'(s_grp) < GROUPS);

  always_comb begin
    kind = SEL_NONE;
    grp  = '0;
    idx  = '0;
    if (p_hit) begin
      kind = SEL_PENDING;
      grp  = p_grp;
      idx  = p_idx;
    end else if (s_hit) begin
      kind = SEL_SUMMARY;
      grp  = s_grp;
    end
  end

endmodule

// File: rtl/msi_pending_reg.sv
module msi_pending_reg #(
  parameter int unsigned VECTORS = 16,
  localparam int unsigned VEC_W  = $clog2(VECTORS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [VEC_W-1:0]   set_sel,
  input  logic               clr_en,
  output logic [VECTORS-1:0] q
);
  logic [VECTORS-1:0] set_mask;
  logic [VECTORS-1:0] kept;

  assign set_mask = set_en ? (VECTORS'(1) << set_sel) : '0;
  // A read returns all of q, so clearing all of q clears only returned bits
  assign kept     = clr_en ? '0 : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= kept | set_mask;
  end

  // R1, R6: a write always lands, even alongside a clearing read
  p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> q[$past(set_sel)]);

  // R5: a read with no write empties the register
  p_read_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> (q == '0));

  // R3: untouched registers keep their contents
  p_untouched_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !set_en) |=> $stable(q));

endmodule

// File: rtl/msi_group_summary.sv
module msi_group_summary #(
  parameter int unsigned INDEXES = 8,
  parameter int unsigned VECTORS = 16
) (
  input  logic [INDEXES*VECTORS-1:0] pend_flat,
  output logic [INDEXES-1:0]         summary,
  output logic                       irq
);
  for (genvar x = 0; x < INDEXES; x++) begin : g_or
    assign summary[x] = |pend_flat[x*VECTORS +: VECTORS];
  end
  assign irq = |summary;
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned GROUPS    = 16,
  parameter int unsigned INDEXES   = 8,
  parameter int unsigned VECTORS   = 16,
  parameter int unsigned REG_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [GROUPS-1:0] irq_out
);
  localparam int unsigned GRP_W = $clog2(GROUPS);
  localparam int unsigned IDX_W = $clog2(INDEXES);
  localparam int unsigned VEC_W = $clog2(VECTORS);
  localparam int unsigned NREG  = GROUPS * INDEXES;

  // Decoded events, named for the assertions
  sel_kind_e           wr_kind, rd_kind;
  logic [GRP_W-1:0]    wr_grp, rd_grp;
  logic [IDX_W-1:0]    wr_idx, rd_idx;
  logic                wr_data_ok;
  logic                wr_accept;
  logic                rd_clear;
  logic [VECTORS-1:0]  pend_q [NREG];
  logic [INDEXES-1:0]  summ [GROUPS];
  logic [DATA_W-1:0]   rd_next;

  msi_addr_decode #(
    .ADDR_W(ADDR_W), .GROUPS(GROUPS), .INDEXES(INDEXES), .REG_SHIFT(REG_SHIFT)
  ) u_wr_dec (
    .addr(wr_addr), .kind(wr_kind), .grp(wr_grp), .idx(wr_idx)
  );

  msi_addr_decode #(
    .ADDR_W(ADDR_W), .GROUPS(GROUPS), .INDEXES(INDEXES), .REG_SHIFT(REG_SHIFT)
  ) u_rd_dec (
    .addr(rd_addr), .kind(rd_kind), .grp(rd_grp), .idx(rd_idx)
  );

  assign wr_data_ok = (wr_data < DATA_W'(VECTORS));
  assign wr_accept  = wr_en && (wr_kind == SEL_PENDING) && wr_data_ok;
  assign rd_clear   = rd_en && (rd_kind == SEL_PENDING);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [INDEXES*VECTORS-1:0] flat;

    for (genvar x = 0; x < INDEXES; x++) begin : g_idx
      logic set_here;
      logic clr_here;
      assign set_here = wr_accept && (wr_grp == GRP_W'(g)) && (wr_idx == IDX_W'(x));
      assign clr_here = rd_clear && (rd_grp == GRP_W'(g)) && (rd_idx == IDX_W'(x));

      msi_pending_reg #(.VECTORS(VECTORS)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_here), .set_sel(wr_data[VEC_W-1:0]),
        .clr_en(clr_here),
        .q(pend_q[flat_slot(g, x, INDEXES)])
      );
    end

    always_comb begin
      for (int x = 0; x < INDEXES; x++) begin
        flat[x*VECTORS +: VECTORS] = pend_q[flat_slot(g, x, INDEXES)];
      end
    end

    msi_group_summary #(.INDEXES(INDEXES), .VECTORS(VECTORS)) u_sum (
      .pend_flat(flat), .summary(summ[g]), .irq(irq_out[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      case (rd_kind)
        SEL_PENDING: rd_next = DATA_W'(pend_q[flat_slot(32'(rd_grp), 32'(rd_idx), INDEXES)]);
        SEL_SUMMARY: rd_next = DATA_W'(summ[rd_grp]);
        default:     rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_kind == SEL_NONE)) |=> (rd_data == '0));

  // R4: no read strobe, no read data
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));

  // R7, R8: a summary read is nonzero exactly when that group's line was high
  p_summary_matches_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_kind == SEL_SUMMARY)) |=> ((rd_data != '0) == $past(irq_out[rd_grp])));

  // R2: oversized data never reaches a register
  p_big_data_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data_ok && !rd_en) |=> $stable(irq_out));

endmodule

// File: tb/msi_term_bank_tb.sv
`timescale 1ns/1ps
module msi_term_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] model [16][8];

  always #2 clk = ~clk;

  msi_term_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [31:0] pend_addr(int g, int x);
    return 32'h80000 * g + 32'h10000 * x;
  endfunction

  function automatic logic [31:0] sum_addr(int g);
    return 32'h800000 + 32'h10000 * g;
  endfunction

  function automatic logic [7:0] model_summary(int g);
    logic [7:0] s = '0;
    for (int x = 0; x < 8; x++) s[x] = (model[g][x] != 16'h0);
    return s;
  endfunction

  function automatic logic [15:0] model_irq();
    logic [15:0] v = '0;
    for (int g = 0; g < 16; g++) v[g] = (model_summary(g) != 8'h0);
    return v;
  endfunction

  function automatic logic [31:0] model_read(bit re, logic [31:0] a);
    if (!re) return 32'h0;
    for (int g = 0; g < 16; g++) begin
      for (int x = 0; x < 8; x++) if (a == pend_addr(g, x)) return {16'h0, model[g][x]};
      if (a == sum_addr(g)) return {24'h0, model_summary(g)};
    end
    return 32'h0;
  endfunction

  function automatic void model_clear_all();
    for (int g = 0; g < 16; g++)
      for (int x = 0; x < 8; x++) model[g][x] = 16'h0;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive after a falling edge, sample at the next falling edge
  task automatic op(bit we, logic [31:0] wa, logic [31:0] wd, bit re, logic [31:0] ra, string tag);
    logic [31:0] exp_rd;
    exp_rd = model_read(re, ra);
    if (re)
      for (int g = 0; g < 16; g++)
        for (int x = 0; x < 8; x++) if (ra == pend_addr(g, x)) model[g][x] = 16'h0;
    if (we && wd < 32'd16)
      for (int g = 0; g < 16; g++)
        for (int x = 0; x < 8; x++) if (wa == pend_addr(g, x)) model[g][x][wd[3:0]] = 1'b1;
    wr_en = we; wr_addr = wa[23:0]; wr_data = wd;
    rd_en = re; rd_addr = ra[23:0];
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rd_data == exp_rd, {tag, " rd_data"}, rd_data, exp_rd);
    check(irq_out == model_irq(), {tag, " irq_out"}, {16'h0, irq_out}, {16'h0, model_irq()});
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d, string tag);
    op(1'b1, a, d, 1'b0, 32'h0, tag);
  endtask

  task automatic rd(logic [31:0] a, string tag);
    op(1'b0, 32'h0, 32'h0, 1'b1, a, tag);
  endtask

  function automatic logic [31:0] rnd_addr();
    int r = $urandom % 10;
    if (r < 6) return pend_addr($urandom % 16, $urandom % 8);
    if (r < 8) return sum_addr($urandom % 16);
    if (r == 8) return pend_addr($urandom % 16, $urandom % 8) + 32'(($urandom % 4) + 1) * 4;
    return $urandom & 32'hFFFFFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    model_clear_all();
    repeat (3) @(negedge clk);
    // R10: reset state
    check(irq_out == 16'h0, "R10 irq in reset", {16'h0, irq_out}, 32'h0);
    check(rd_data == 32'h0, "R10 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(pend_addr(0, 0), "R10 empty after reset");
    rd(sum_addr(15), "R10 summary empty");

    // R1, R5: set and read-to-clear
    wr(pend_addr(3, 5), 32'd9, "R1 set bit 9");
    rd(pend_addr(3, 5), "R5 read returns 0x200");
    rd(pend_addr(3, 5), "R5 second read empty");
    wr(pend_addr(15, 7), 32'd15, "R1 top register bit 15");
    wr(pend_addr(15, 7), 32'd0, "R1 top register bit 0");
    rd(pend_addr(15, 7), "R5 read 0x8001");

    // R2: oversized data
    wr(pend_addr(0, 0), 32'd16, "R2 data 16");
    wr(pend_addr(0, 0), 32'hFFFF, "R2 data 0xFFFF");
    rd(pend_addr(0, 0), "R2 nothing set");

    // R3: off-map write addresses
    wr(pend_addr(1, 1) + 32'h4, 32'd2, "R3 low bits set");
    wr(sum_addr(1), 32'd2, "R3 summary address");
    wr(32'h900000, 32'd2, "R3 above summaries");
    rd(pend_addr(1, 1), "R3 register untouched");

    // R7, R8: summary and interrupt line
    wr(pend_addr(2, 1), 32'd0, "R8 line rises");
    wr(pend_addr(2, 6), 32'd15, "R7 second index");
    rd(sum_addr(2), "R7 summary 0x42");
    rd(sum_addr(2), "R7 summary read has no side effect");
    rd(pend_addr(2, 1), "R8 drain index 1");
    rd(pend_addr(2, 6), "R8 drain index 6, line falls");
    rd(sum_addr(2), "R8 summary now zero");

    // R6: write and clearing read on the same register
    wr(pend_addr(7, 7), 32'd3, "R6 prime bit 3");
    op(1'b1, pend_addr(7, 7), 32'd4, 1'b1, pend_addr(7, 7), "R6 merge returns old");
    rd(pend_addr(7, 7), "R6 written bit survives");

    // R9: unmapped reads
    wr(pend_addr(4, 2), 32'd7, "R9 prime");
    rd(32'h8F0004, "R9 unmapped low bits");
    rd(32'hC00000, "R9 unmapped high");
    rd(pend_addr(4, 2) + 32'h100, "R9 near pending address");
    rd(pend_addr(4, 2), "R9 register kept");

    // R4: idle cycle gives zero read data
    op(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, "R4 idle");

    // R10: reset in mid-run
    wr(pend_addr(9, 3), 32'd1, "R10 prime");
    rst_n = 1'b0;
    @(negedge clk);
    model_clear_all();
    check(irq_out == 16'h0, "R10 reset clears lines", {16'h0, irq_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(pend_addr(9, 3), "R10 register cleared");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 3) != 0;
      bit re = ($urandom % 2) != 0;
      logic [31:0] wa = rnd_addr();
      logic [31:0] ra = (($urandom % 4) == 0) ? wa : rnd_addr();
      logic [31:0] wd = (($urandom % 8) == 0) ? $urandom : ($urandom % 16);
      op(we, wa, wd, re, ra, "R1/R5/R6/R7 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule